// File: doc/BRIEF.md
# Hotplug Slot Status Controller

This block keeps, for each of several selectable buses, a 32-slot record of pending hot-insert notices, pending remove requests and a mask of removable slots. Platform logic reports insertions and removal requests through two strobes carrying a bus number and a slot number. The block raises a one-cycle event pulse so that system software can come and look. Software reaches the record through a six-word register window. It picks a bus, reads the bitmaps, ejects a slot or fetches a slot's index value from an external per-slot table. An eject leaves the block as a one-cycle strobe carrying bus and slot, for the logic that actually removes the device.

A warm-reset input starts a sweep. The sweep ejects every pending remove request, bus 0 first and each bus from its lowest pending slot upward, one per cycle. It then reloads the removable masks from the not-hotpluggable table. A legacy input keeps insert notices across reads and pins the bus select to 0.

Top module: `hpslot_ctrl`

## Requirements
- R1: After the synchronous reset `rst`, every insert and remove bitmap is zero, the select register and the latched index are zero, `event_pulse`, `eject_valid` and `sweep_busy` are low, and each bus's removable mask equals the bitwise complement of its 32-bit field in `nohp_mask` (bus b at bits b*32+31..b*32).
- R2: A `plug_valid` strobe whose bus is below NUM_BUS sets that slot's bit in the insert bitmap. A matching `unrm_valid` strobe sets the bit in the remove bitmap. Either strobe drives `event_pulse` high in the next cycle only. A strobe naming a bus at or above NUM_BUS changes nothing and gives no pulse.
- R3: Register words sit at byte offsets 0x00 insert bitmap, 0x04 remove bitmap, 0x08 eject (reads 0), 0x0C removable mask, 0x10 select and 0x14 index, all for the selected bus. A read returns its data on `rsp_rdata` with `rsp_valid` one cycle after the request. Accesses with a nonzero `req_addr[1:0]`, or at 0x18 or 0x1C, read 0, and writes to them have no effect.
- R4: Reading 0x00 clears the selected bus's insert bitmap, unless `legacy_mode` is high. A plug strobe arriving in the same cycle as the clearing read keeps its bit.
- R5: Writing 0x10 stores all 32 data bits, or 0 when `legacy_mode` is high. While the select value is NUM_BUS or more, every read returns 0 and has no side effect.
- R6: Writing 0x08 with a valid select and nonzero data takes the lowest set data bit as the slot. It clears that slot in both the insert and remove bitmaps and drives `eject_valid` with `eject_bus`/`eject_slot` for one cycle, starting the cycle after the write. Zero data or an invalid select does nothing.
- R7: When an eject clear and a plug or unplug-request strobe hit the same bit in the same cycle, the bit ends up clear.
- R8: Every write to a mapped offset clears the latched index. A write to 0x14 with a valid select and nonzero data then latches `idx_lkp_value`, looked up that cycle at `idx_lkp_bus` = select and `idx_lkp_slot` = lowest set data bit.
- R9: Reading 0x14 returns the latched index, zero-extended, and then clears it.
- R10: A `warm_rst` pulse starts a sweep with `sweep_busy` high. The sweep ejects each pending remove request, buses ascending and slots ascending within a bus, one `eject_valid` per cycle, and clears those slots in both bitmaps. It then reloads every removable mask from `nohp_mask`.
- R11: Register writes in the `warm_rst` cycle and while `sweep_busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_mode | input | 1 | Keep insert bits on read; select pinned to 0 |
| warm_rst | input | 1 | Start the pending-remove sweep |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte offset in the window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| plug_valid | input | 1 | Hot-insert notice |
| plug_bus | input | BUS_W | Bus of the insert notice |
| plug_slot | input | 5 | Slot of the insert notice |
| unrm_valid | input | 1 | Remove request |
| unrm_bus | input | BUS_W | Bus of the remove request |
| unrm_slot | input | 5 | Slot of the remove request |
| nohp_mask | input | NUM_BUS*32 | Not-hotpluggable slots, 32 bits per bus |
| idx_lkp_bus | output | BUS_W | Index table lookup bus |
| idx_lkp_slot | output | 5 | Index table lookup slot |
| idx_lkp_value | input | IDX_W | Index table value for the lookup |
| event_pulse | output | 1 | One-cycle system event |
| eject_valid | output | 1 | Eject strobe |
| eject_bus | output | BUS_W | Bus to eject on |
| eject_slot | output | 5 | Slot to eject |
| sweep_busy | output | 1 | Sweep in progress |

## Verification
The bench builds the block with NUM_BUS = 3 and IDX_W = 14. With three buses the 2-bit bus ports can still carry the value 3, so an out-of-range strobe is reachable at the port. Select values of 3 and 4 sit just past the limit, and the sweep walks a bus that has no pending requests between two that do. Random sequences of strobes, selects, ejects and index fetches, including multi-bit and zero eject data, run in both normal and legacy mode against a bench model. Directed cases cover same-cycle collisions and the sweep order.

// File: rtl/hpslot_pkg.sv
package hpslot_pkg;
  localparam int REG_W  = 32;
  localparam int SLOT_N = 32;
  localparam int SLOT_W = 5;

  // word offsets inside the window (software decodes these)
  localparam logic [2:0] WD_INS = 3'd0;
  localparam logic [2:0] WD_REM = 3'd1;
  localparam logic [2:0] WD_EJ  = 3'd2;
  localparam logic [2:0] WD_RMV = 3'd3;
  localparam logic [2:0] WD_SEL = 3'd4;
  localparam logic [2:0] WD_IDX = 3'd5;

  typedef enum logic [1:0] {
    SW_IDLE = 2'd0,
    SW_WALK = 2'd1,
    SW_LOAD = 2'd2
  } sweep_st_e;
endpackage

// File: rtl/hpslot_lsb.sv
module hpslot_lsb #(
  parameter int W  = 32,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = |vec;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/hpslot_bitmaps.sv
module hpslot_bitmaps #(
  parameter int NUM_BUS = 4,
  parameter int BUS_W   = 2,
  parameter int SLOT_N  = 32,
  parameter int SLOT_W  = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_BUS*SLOT_N-1:0] nohp_flat,
  input  logic                      plug_v,
  input  logic [BUS_W-1:0]          plug_bus,
  input  logic [SLOT_W-1:0]         plug_slot,
  input  logic                      unrm_v,
  input  logic [BUS_W-1:0]          unrm_bus,
  input  logic [SLOT_W-1:0]         unrm_slot,
  input  logic                      clr_v,
  input  logic [BUS_W-1:0]          clr_bus,
  input  logic [SLOT_W-1:0]         clr_slot,
  input  logic                      rdclr_v,
  input  logic [BUS_W-1:0]          rdclr_bus,
  input  logic                      rmv_load,
  output logic [NUM_BUS*SLOT_N-1:0] ins_flat,
  output logic [NUM_BUS*SLOT_N-1:0] rem_flat,
  output logic [NUM_BUS*SLOT_N-1:0] rmv_flat
);
  for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
    logic [SLOT_N-1:0] ins_q, rem_q, rmv_q;
    logic [SLOT_N-1:0] set_i, set_r, clr_m, rd_m;

    assign set_i = (plug_v && plug_bus == BUS_W'(b)) ? (SLOT_N'(1) << plug_slot) : '0;
    assign set_r = (unrm_v && unrm_bus == BUS_W'(b)) ? (SLOT_N'(1) << unrm_slot) : '0;
    assign clr_m = (clr_v  && clr_bus  == BUS_W'(b)) ? (SLOT_N'(1) << clr_slot)  : '0;
    assign rd_m  = (rdclr_v && rdclr_bus == BUS_W'(b)) ? '1 : '0;

    always_ff @(posedge clk) begin
      if (rst) begin
        ins_q <= '0;
        rem_q <= '0;
        rmv_q <= ~nohp_flat[b*SLOT_N +: SLOT_N];
      end else begin
        // new notice beats read-clear; eject clear beats everything
        ins_q <= ((ins_q & ~rd_m) | set_i) & ~clr_m;
        rem_q <= (rem_q | set_r) & ~clr_m;
        if (rmv_load) rmv_q <= ~nohp_flat[b*SLOT_N +: SLOT_N];
      end
    end

    assign ins_flat[b*SLOT_N +: SLOT_N] = ins_q;
    assign rem_flat[b*SLOT_N +: SLOT_N] = rem_q;
    assign rmv_flat[b*SLOT_N +: SLOT_N] = rmv_q;

    assert_plug_sets_R2: assert property (@(posedge clk) disable iff (rst)
      (plug_v && plug_bus == BUS_W'(b) &&
       !(clr_v && clr_bus == BUS_W'(b) && clr_slot == plug_slot))
      |=> ins_q[$past(plug_slot)]);

    assert_unrm_sets_R2: assert property (@(posedge clk) disable iff (rst)
      (unrm_v && unrm_bus == BUS_W'(b) &&
       !(clr_v && clr_bus == BUS_W'(b) && clr_slot == unrm_slot))
      |=> rem_q[$past(unrm_slot)]);

    assert_eject_wins_R7: assert property (@(posedge clk) disable iff (rst)
      (clr_v && clr_bus == BUS_W'(b))
      |=> (!ins_q[$past(clr_slot)] && !rem_q[$past(clr_slot)]));
  end
endmodule

// File: rtl/hpslot_sweep.sv
module hpslot_sweep
  import hpslot_pkg::*;
#(
  parameter int NUM_BUS = 4,
  parameter int BUS_W   = 2,
  parameter int SLOT_N  = 32,
  parameter int SLOT_W  = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [NUM_BUS*SLOT_N-1:0] rem_flat,
  output logic                      busy,
  output logic                      clr_v,
  output logic [BUS_W-1:0]          clr_bus,
  output logic [SLOT_W-1:0]         clr_slot,
  output logic                      rmv_load
);
  sweep_st_e         st_q;
  logic [BUS_W-1:0]  bus_q;
  logic [SLOT_N-1:0] rem_cur;
  logic              pend;
  logic [SLOT_W-1:0] pend_slot;

  assign rem_cur = rem_flat[int'(bus_q)*SLOT_N +: SLOT_N];

  hpslot_lsb #(.W(SLOT_N), .IW(SLOT_W)) u_pick (
    .vec(rem_cur), .found(pend), .idx(pend_slot)
  );

  assign busy     = (st_q != SW_IDLE);
  assign clr_v    = (st_q == SW_WALK) && pend;
  assign clr_bus  = bus_q;
  assign clr_slot = pend_slot;
  assign rmv_load = (st_q == SW_LOAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SW_IDLE;
      bus_q <= '0;
    end else begin
      unique case (st_q)
        SW_IDLE: if (start) begin
          st_q  <= SW_WALK;
          bus_q <= '0;
        end
        SW_WALK: if (!pend) begin
          if (bus_q == BUS_W'(NUM_BUS - 1)) st_q <= SW_LOAD;
          else bus_q <= BUS_W'(bus_q + 1'b1);
        end
        SW_LOAD: st_q <= SW_IDLE;
        default: st_q <= SW_IDLE;
      endcase
    end
  end

  assert_bus_order_R10: assert property (@(posedge clk) disable iff (rst)
    (clr_v && $past(clr_v)) |-> (clr_bus >= $past(clr_bus)));

  assert_load_ends_R10: assert property (@(posedge clk) disable iff (rst)
    rmv_load |=> !busy);
endmodule

// File: rtl/hpslot_ctrl.sv
module hpslot_ctrl
  import hpslot_pkg::*;
#(
  parameter int  NUM_BUS = 4,
  parameter int  IDX_W   = 14,
  localparam int BUS_W   = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      legacy_mode,
  input  logic                      warm_rst,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic [4:0]                req_addr,
  input  logic [REG_W-1:0]          req_wdata,
  output logic                      rsp_valid,
  output logic [REG_W-1:0]          rsp_rdata,
  input  logic                      plug_valid,
  input  logic [BUS_W-1:0]          plug_bus,
  input  logic [SLOT_W-1:0]         plug_slot,
  input  logic                      unrm_valid,
  input  logic [BUS_W-1:0]          unrm_bus,
  input  logic [SLOT_W-1:0]         unrm_slot,
  input  logic [NUM_BUS*SLOT_N-1:0] nohp_mask,
  output logic [BUS_W-1:0]          idx_lkp_bus,
  output logic [SLOT_W-1:0]         idx_lkp_slot,
  input  logic [IDX_W-1:0]          idx_lkp_value,
  output logic                      event_pulse,
  output logic                      eject_valid,
  output logic [BUS_W-1:0]          eject_bus,
  output logic [SLOT_W-1:0]         eject_slot,
  output logic                      sweep_busy
);
  logic [REG_W-1:0] sel_q;
  logic [IDX_W-1:0] idx_q;
  logic [2:0]       word;
  logic             acc_ok, sel_ok, wr_en, rd_en;
  logic [BUS_W-1:0] sel_b;
  logic             wd_found;
  logic [SLOT_W-1:0] wd_slot;
  logic             ej_hit, ix_hit, rdclr_v;
  logic             plug_ok, unrm_ok;
  logic [NUM_BUS*SLOT_N-1:0] ins_flat, rem_flat, rmv_flat;
  logic             sw_busy, sw_clr_v, sw_load;
  logic [BUS_W-1:0] sw_clr_bus;
  logic [SLOT_W-1:0] sw_clr_slot;
  logic             clr_v;
  logic [BUS_W-1:0] clr_bus;
  logic [SLOT_W-1:0] clr_slot;
  logic [REG_W-1:0] rd_val;

  assign word    = req_addr[4:2];
  assign acc_ok  = (req_addr[1:0] == 2'b00) && (word <= WD_IDX);
  assign sel_ok  = (sel_q < REG_W'(NUM_BUS));
  assign sel_b   = sel_q[BUS_W-1:0];
  assign wr_en   = req_valid && req_write && acc_ok && !sw_busy && !warm_rst;
  assign rd_en   = req_valid && !req_write && acc_ok;
  assign plug_ok = plug_valid && (32'(plug_bus) < NUM_BUS);
  assign unrm_ok = unrm_valid && (32'(unrm_bus) < NUM_BUS);

  hpslot_lsb #(.W(REG_W), .IW(SLOT_W)) u_wd_pick (
    .vec(req_wdata), .found(wd_found), .idx(wd_slot)
  );

  assign ej_hit  = wr_en && (word == WD_EJ)  && sel_ok && wd_found;
  assign ix_hit  = wr_en && (word == WD_IDX) && sel_ok && wd_found;
  assign rdclr_v = rd_en && (word == WD_INS) && sel_ok && !legacy_mode;

  assign idx_lkp_bus  = sel_b;
  assign idx_lkp_slot = wd_slot;

  // sweep owns the clear port while busy; writes are blocked then
  assign clr_v    = sw_clr_v || ej_hit;
  assign clr_bus  = sw_clr_v ? sw_clr_bus  : sel_b;
  assign clr_slot = sw_clr_v ? sw_clr_slot : wd_slot;

  hpslot_sweep #(.NUM_BUS(NUM_BUS), .BUS_W(BUS_W), .SLOT_N(SLOT_N), .SLOT_W(SLOT_W)) u_sweep (
    .clk(clk), .rst(rst), .start(warm_rst), .rem_flat(rem_flat),
    .busy(sw_busy), .clr_v(sw_clr_v), .clr_bus(sw_clr_bus),
    .clr_slot(sw_clr_slot), .rmv_load(sw_load)
  );

  hpslot_bitmaps #(.NUM_BUS(NUM_BUS), .BUS_W(BUS_W), .SLOT_N(SLOT_N), .SLOT_W(SLOT_W)) u_maps (
    .clk(clk), .rst(rst), .nohp_flat(nohp_mask),
    .plug_v(plug_ok), .plug_bus(plug_bus), .plug_slot(plug_slot),
    .unrm_v(unrm_ok), .unrm_bus(unrm_bus), .unrm_slot(unrm_slot),
    .clr_v(clr_v), .clr_bus(clr_bus), .clr_slot(clr_slot),
    .rdclr_v(rdclr_v), .rdclr_bus(sel_b), .rmv_load(sw_load),
    .ins_flat(ins_flat), .rem_flat(rem_flat), .rmv_flat(rmv_flat)
  );

  always_comb begin
    rd_val = '0;
    if (sel_ok) begin
      unique case (word)
        WD_INS:  rd_val = ins_flat[int'(sel_b)*SLOT_N +: SLOT_N];
        WD_REM:  rd_val = rem_flat[int'(sel_b)*SLOT_N +: SLOT_N];
        WD_RMV:  rd_val = rmv_flat[int'(sel_b)*SLOT_N +: SLOT_N];
        WD_SEL:  rd_val = sel_q;
        WD_IDX:  rd_val = REG_W'(idx_q);
        default: rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q       <= '0;
      idx_q       <= '0;
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      event_pulse <= 1'b0;
      eject_valid <= 1'b0;
      eject_bus   <= '0;
      eject_slot  <= '0;
      sweep_busy  <= 1'b0;
    end else begin
      rsp_valid   <= req_valid && !req_write;
      rsp_rdata   <= rd_en ? rd_val : '0;
      event_pulse <= plug_ok || unrm_ok;
      eject_valid <= clr_v;
      eject_bus   <= clr_bus;
      eject_slot  <= clr_slot;
      sweep_busy  <= warm_rst || (sw_busy && !sw_load);
      if (wr_en) begin
        idx_q <= '0;
        if (word == WD_SEL) sel_q <= legacy_mode ? '0 : req_wdata;
        if (ix_hit) idx_q <= idx_lkp_value;
      end else if (rd_en && sel_ok && word == WD_IDX) begin
        idx_q <= '0;
      end
    end
  end

  assert_event_follows_R2: assert property (@(posedge clk) disable iff (rst)
    (plug_ok || unrm_ok) |=> event_pulse);

  assert_bad_sel_reads0_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && !sel_ok) |=> (rsp_rdata == '0));

  assert_write_clears_idx_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && word != WD_IDX) |=> (idx_q == '0));

  assert_sweep_blocks_write_R11: assert property (@(posedge clk) disable iff (rst)
    (sw_busy && req_valid && req_write && word == WD_SEL) |=> $stable(sel_q));
endmodule

// File: tb/tb_hpslot_ctrl.sv
module tb_hpslot_ctrl;
  localparam int NB = 3;
  localparam int BW = 2;

  logic clk = 1'b0;
  logic rst, legacy_mode, warm_rst;
  logic req_valid, req_write;
  logic [4:0] req_addr;
  logic [31:0] req_wdata, rsp_rdata;
  logic rsp_valid;
  logic plug_valid, unrm_valid;
  logic [BW-1:0] plug_bus, unrm_bus, idx_lkp_bus, eject_bus;
  logic [4:0] plug_slot, unrm_slot, idx_lkp_slot, eject_slot;
  logic [NB*32-1:0] nohp_mask;
  logic [13:0] idx_lkp_value;
  logic event_pulse, eject_valid, sweep_busy;

  int n_chk = 0, n_err = 0;
  logic [31:0] m_ins [NB], m_rem [NB], m_rmv [NB];
  logic [31:0] m_sel, m_idx;
  bit sweep_mon = 0;
  int log_n = 0;
  int log_b [16], log_s [16];

  always #2 clk = ~clk;

  function automatic logic [13:0] tbl(int b, int s);
    return 14'((b * 1237 + s * 389 + 17) % 16384);
  endfunction

  function automatic int ctz(logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return 32;
  endfunction

  assign idx_lkp_value = tbl(int'(idx_lkp_bus), int'(idx_lkp_slot));

  hpslot_ctrl #(.NUM_BUS(NB), .IDX_W(14)) dut (
    .clk(clk), .rst(rst), .legacy_mode(legacy_mode), .warm_rst(warm_rst),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .plug_valid(plug_valid), .plug_bus(plug_bus), .plug_slot(plug_slot),
    .unrm_valid(unrm_valid), .unrm_bus(unrm_bus), .unrm_slot(unrm_slot),
    .nohp_mask(nohp_mask), .idx_lkp_bus(idx_lkp_bus), .idx_lkp_slot(idx_lkp_slot),
    .idx_lkp_value(idx_lkp_value), .event_pulse(event_pulse),
    .eject_valid(eject_valid), .eject_bus(eject_bus), .eject_slot(eject_slot),
    .sweep_busy(sweep_busy)
  );

  always @(negedge clk) begin
    if (sweep_mon && eject_valid && log_n < 16) begin
      log_b[log_n] = int'(eject_bus);
      log_s[log_n] = int'(eject_slot);
      log_n++;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_req();
    req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    plug_valid = 0; unrm_valid = 0;
  endtask

  // read with model side effects; returns after sampling
  task automatic do_read(input logic [4:0] a);
    logic [31:0] e;
    string tag;
    e = 0; tag = "R3";
    if (a[1:0] == 0 && a[4:2] <= 5) begin
      if (m_sel >= NB) tag = "R5";
      else begin
        case (a[4:2])
          3'd0: begin e = m_ins[m_sel]; tag = "R4"; if (!legacy_mode) m_ins[m_sel] = 0; end
          3'd1: e = m_rem[m_sel];
          3'd3: e = m_rmv[m_sel];
          3'd4: e = m_sel;
          3'd5: begin e = m_idx; m_idx = 0; tag = "R9"; end
          default: e = 0;
        endcase
      end
    end
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    clear_req();
    check("R3 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    check(tag, rsp_rdata, e);
  endtask

  task automatic do_write(input logic [4:0] a, input logic [31:0] d);
    bit ev; int eb, es;
    ev = 0; eb = 0; es = 0;
    if (a[1:0] == 0 && a[4:2] <= 5) begin
      m_idx = 0;
      case (a[4:2])
        3'd2: if (m_sel < NB && d != 0) begin
          es = ctz(d); eb = int'(m_sel); ev = 1;
          m_ins[m_sel][es] = 1'b0; m_rem[m_sel][es] = 1'b0;
        end
        3'd4: m_sel = legacy_mode ? 32'd0 : d;
        3'd5: if (m_sel < NB && d != 0) m_idx = 32'(tbl(int'(m_sel), ctz(d)));
        default: ;
      endcase
    end
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    clear_req();
    check("R6 eject_valid", {31'b0, eject_valid}, {31'b0, ev});
    if (ev) begin
      check("R6 eject_bus", 32'(eject_bus), 32'(eb));
      check("R6 eject_slot", 32'(eject_slot), 32'(es));
    end
  endtask

  task automatic do_strobe(input bit rem, input int b, input int s);
    if (rem) begin unrm_valid = 1; unrm_bus = BW'(b); unrm_slot = 5'(s); end
    else     begin plug_valid = 1; plug_bus = BW'(b); plug_slot = 5'(s); end
    @(negedge clk);
    clear_req();
    check("R2 event", {31'b0, event_pulse}, {31'b0, (b < NB)});
    if (b < NB) begin
      if (rem) m_rem[b][s] = 1'b1; else m_ins[b][s] = 1'b1;
    end
    @(negedge clk);
    check("R2 pulse width", {31'b0, event_pulse}, 32'd0);
  endtask

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin
      m_ins[b] = 0; m_rem[b] = 0; m_rmv[b] = ~nohp_mask[b*32 +: 32];
    end
    m_sel = 0; m_idx = 0;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] pre;
    void'($urandom(32'd20240611));
    rst = 1; legacy_mode = 0; warm_rst = 0;
    plug_bus = '0; plug_slot = '0; unrm_bus = '0; unrm_slot = '0;
    clear_req();
    nohp_mask = {32'h0000_00F0, 32'h8000_0001, 32'h0F0F_0000};
    repeat (3) @(negedge clk);
    rst = 0;
    model_reset();

    // R1 reset state
    check("R1 event", {31'b0, event_pulse}, 0);
    check("R1 eject", {31'b0, eject_valid}, 0);
    check("R1 busy", {31'b0, sweep_busy}, 0);
    for (int b = 0; b < NB; b++) begin
      do_write(5'h10, 32'(b));
      do_read(5'h0C); do_read(5'h00); do_read(5'h04); do_read(5'h14);
    end
    do_write(5'h10, 0);
    do_read(5'h10);

    // R2 strobes, including out-of-range bus 3
    do_strobe(0, 1, 4); do_strobe(1, 1, 20); do_strobe(0, 3, 7); do_strobe(1, 3, 9);
    do_write(5'h10, 1);
    do_read(5'h04); do_read(5'h00); do_read(5'h00);

    // R3 unmapped and misaligned
    do_read(5'h18); do_read(5'h1C); do_read(5'h01);
    do_write(5'h13, 32'h2); do_read(5'h10);

    // R4 legacy keeps insert bits; R5 legacy select write
    legacy_mode = 1;
    do_strobe(0, 1, 2);
    do_read(5'h00); do_read(5'h00);
    do_write(5'h10, 2); do_read(5'h10);
    legacy_mode = 0;
    do_read(5'h00); do_read(5'h00);

    // R4 plug in same cycle as clearing read
    do_write(5'h10, 1);
    do_strobe(0, 1, 3);
    pre = m_ins[1];
    plug_valid = 1; plug_bus = 2'd1; plug_slot = 5'd9;
    req_valid = 1; req_write = 0; req_addr = 5'h00;
    @(negedge clk);
    clear_req();
    check("R4 read with plug", rsp_rdata, pre);
    m_ins[1] = 32'h0000_0200;
    do_read(5'h00);

    // R7 eject beats plug and unplug request on same bit
    unrm_valid = 1; unrm_bus = 2'd1; unrm_slot = 5'd5;
    plug_valid = 1; plug_bus = 2'd1; plug_slot = 5'd5;
    req_valid = 1; req_write = 1; req_addr = 5'h08; req_wdata = 32'h0000_0020;
    @(negedge clk);
    clear_req();
    check("R7 eject", {31'b0, eject_valid}, 1);
    check("R7 event", {31'b0, event_pulse}, 1);
    do_read(5'h04); do_read(5'h00);

    // R6 multi-bit eject, zero data, invalid select
    do_strobe(1, 2, 12); do_strobe(1, 2, 30);
    do_write(5'h10, 2);
    do_write(5'h08, 32'hC000_1000); do_read(5'h04);
    do_write(5'h08, 0);
    do_write(5'h10, 3); do_write(5'h08, 32'h4000_0000);
    do_read(5'h04); do_read(5'h10);

    // R8 / R9 index fetch
    do_write(5'h10, 2);
    do_write(5'h14, 32'h0000_0100); do_read(5'h14); do_read(5'h14);
    do_write(5'h14, 32'h8000_0000); do_write(5'h10, 2); do_read(5'h14);
    do_write(5'h14, 32'h0000_0003); do_read(5'h10); do_read(5'h14);
    do_write(5'h10, 4); do_write(5'h14, 1); do_read(5'h14);
    do_write(5'h10, 0); do_write(5'h14, 0); do_read(5'h14);

    // random mix
    for (int it = 0; it < 600; it++) begin
      int op; logic [31:0] d;
      op = int'($urandom % 9);
      if (it % 150 == 0) legacy_mode = ($urandom % 3 == 0);
      d = $urandom;
      if ($urandom % 3 == 0) d = 32'h1 << ($urandom % 32);
      case (op)
        0, 1: do_strobe(0, int'($urandom % 4), int'($urandom % 32));
        2:    do_strobe(1, int'($urandom % 4), int'($urandom % 32));
        3:    do_write(5'h10, 32'($urandom % 5));
        4:    do_write(5'h08, ($urandom % 5 == 0) ? 32'd0 : d);
        5:    do_write(5'h14, d);
        6:    do_read(5'h14);
        default: do_read(5'(($urandom % 8) * 4 + (($urandom % 8 == 0) ? 1 : 0)));
      endcase
    end
    legacy_mode = 0;

    // R10 / R11 sweep
    nohp_mask = {32'h0000_000F, 32'h00FF_0000, 32'hF000_0000};
    do_write(5'h10, 0); do_read(5'h0C);
    for (int b = 0; b < NB; b++) begin
      do_write(5'h10, 32'(b));
      do_write(5'h08, m_rem[b]);
      while (m_rem[b] != 0) do_write(5'h08, m_rem[b]);
    end
    do_strobe(1, 0, 17); do_strobe(1, 0, 3); do_strobe(1, 2, 31); do_strobe(1, 2, 0);
    do_strobe(0, 2, 31);
    do_write(5'h10, 1);
    sweep_mon = 1; log_n = 0;
    warm_rst = 1;
    @(negedge clk);
    warm_rst = 0;
    check("R10 busy", {31'b0, sweep_busy}, 1);
    req_valid = 1; req_write = 1; req_addr = 5'h10; req_wdata = 32'd2;
    @(negedge clk);
    clear_req();
    for (int i = 0; i < 200 && sweep_busy; i++) @(negedge clk);
    sweep_mon = 0;
    check("R10 done", {31'b0, sweep_busy}, 0);
    check("R10 count", 32'(log_n), 32'd4);
    check("R10 e0", 32'(log_b[0] * 64 + log_s[0]), 32'(0 * 64 + 3));
    check("R10 e1", 32'(log_b[1] * 64 + log_s[1]), 32'(0 * 64 + 17));
    check("R10 e2", 32'(log_b[2] * 64 + log_s[2]), 32'(2 * 64 + 0));
    check("R10 e3", 32'(log_b[3] * 64 + log_s[3]), 32'(2 * 64 + 31));
    m_rem[0] = 0; m_rem[2] = 0; m_ins[2][31] = 1'b0; m_ins[2][0] = 1'b0;
    m_ins[0][3] = 1'b0; m_ins[0][17] = 1'b0;
    for (int b = 0; b < NB; b++) m_rmv[b] = ~nohp_mask[b*32 +: 32];
    do_read(5'h10); // R11: write during sweep ignored, select stays 1
    for (int b = 0; b < NB; b++) begin
      do_write(5'h10, 32'(b));
      do_read(5'h04); do_read(5'h0C); do_read(5'h00);
    end

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule